// File: doc/BRIEF.md
# Double-Buffered DAC Input Interface

This block is the synchronous digital front end of a 14-bit voltage-output converter. It keeps two 14-bit registers in series: a staging register that collects a new code, and an output register whose contents alone set the converter code. A new code reaches the staging register in one of two ways, picked by a mode input:

- **Parallel mode:** a 14-bit bus is qualified by an active-low chip select and an active-low write.
- **Serial mode:** a three-wire port with a clock, an active-low frame and a data line.

A separate active-low load strobe copies the staging register into the output register. The same output value is also presented as a signed two's-complement number for downstream checking.

Every asynchronous pin passes through a two-stage synchronizer before any level or edge decision is made. Both registers behave as level-transparent latches and are interlocked. While a parallel write is open, the output register holds, even if the load strobe is low. If the load strobe is tied low, the output follows the staging register as soon as each write closes.

Top module: `dac_frontend`

## Requirements
- R1: After reset both registers are zero, so `dacCode` is 0 and `dacValue` is 0 (mid-scale).
- R2: In parallel mode, while `chipSelN` and `writeN` are both low, the staging register follows `parBus`. Bit 13 is the MSB and bit 0 the LSB, and all bits load together. A later low level on `loadN` moves that code to `dacCode`.
- R3: When either `chipSelN` or `writeN` returns high, the staging register keeps the bus value present at that moment. Later changes on `parBus` have no effect.
- R4: While a parallel write is open, `dacCode` holds its previous value even with `loadN` low. With `loadN` held low, `dacCode` takes the new code once the write closes.
- R5: While `loadN` is high, `dacCode` does not change, whatever happens to the staging register.
- R6: In serial mode a frame is opened by `serFrameN` low. Bits are sampled from `serData` on each falling edge of `serClk`, MSB first. When the 16th bit arrives, the last 14 bits received go to the staging register. The first two bits are discarded.
- R7: If `serFrameN` rises before 16 bits have been received, the partial frame is dropped and the staging register keeps its old code.
- R8: The mode input `serialSel` selects the load path: 1 means serial, 0 means parallel. In serial mode the parallel pins cannot change the staging register. In parallel mode the serial pins cannot change it.
- R9: `dacValue` is the two's-complement reading of `dacCode`: 0x1FFF is +8191, 0x2000 is -8192, 0x3FFF is -1.
- R10: Falling clock edges after the 16th within the same frame are ignored until `serFrameN` goes high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serialSel | input | 1 | Load path select: 1 serial, 0 parallel |
| parBus | input | 14 | Parallel code, bit 13 MSB |
| chipSelN | input | 1 | Active-low chip select for parallel writes |
| writeN | input | 1 | Active-low write for parallel writes |
| loadN | input | 1 | Active-low transfer strobe, staging to output register |
| serClk | input | 1 | Serial clock, data taken on falling edge |
| serFrameN | input | 1 | Active-low serial frame |
| serData | input | 1 | Serial data, MSB first |
| dacCode | output | 14 | Output register contents |
| dacValue | output | 14 | Output register as signed two's complement |

## Verification
The bench sweeps a spread of codes through both load paths, including the two extreme codes. A design that treated the code as unsigned would report +8192 instead of -8192. A design that kept the wrong 14 bits of a serial frame would show shifted or truncated codes.

The bench holds the load strobe low across an open write. A broken interlock would let the output walk with the bus before the write closes. The bench also moves the bus after a write closes, which catches a register that stays transparent.

Short frames, over-long frames and traffic on the path that is not selected are all checked at the output. A design that loads partial frames, accepts extra bits, or mixes the two paths would change `dacCode`.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  // Strobes from control to datapath, one cycle's worth of decisions
  typedef struct packed {
    logic parTrack;   // staging register follows the parallel bus
    logic shiftEn;    // shift one serial bit in
    logic serLoad;    // final bit of a frame: load staging register
    logic bitIn;      // synchronized serial data bit
    logic dacTrack;   // output register follows staging register
  } dacStrobes_t;

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int CHAIN = (STAGES < 2) ? 2 : STAGES;

  logic [CHAIN-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {CHAIN{RST_VAL}};
    else       chain <= {chain[CHAIN-2:0], din};
  end

  assign dout = chain[CHAIN-1];

endmodule

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serialSel,
  input  logic        chipSelN,
  input  logic        writeN,
  input  logic        loadN,
  input  logic        serClk,
  input  logic        serFrameN,
  input  logic        serData,
  output dacStrobes_t strobes
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_LEN);

  // Idle levels: active-low pins high, serial clock high, mode parallel
  localparam logic [6:0] PIN_IDLE = 7'b0111110;

  logic [6:0] pinRaw, pinSync;
  logic modeS, csS, wrS, ldS, sclkS, frameS, dataS;

  assign pinRaw = {serialSel, chipSelN, writeN, loadN, serClk, serFrameN, serData};

  dacfe_sync #(.WIDTH(7), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) uPinSync (
    .clk (clk),
    .rstN(rstN),
    .din (pinRaw),
    .dout(pinSync)
  );

  assign {modeS, csS, wrS, ldS, sclkS, frameS, dataS} = pinSync;

  logic             sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             sclkFall, frameOpen, shiftNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b1;
    else       sclkPrev <= sclkS;
  end

  assign sclkFall  = sclkPrev & ~sclkS;
  assign frameOpen = modeS & ~frameS;
  assign shiftNow  = frameOpen & sclkFall & (bitCnt < FULL_CNT);

  // Bit counter: cleared whenever no frame is open, saturates at FULL_CNT
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          bitCnt <= '0;
    else if (!frameOpen) bitCnt <= '0;
    else if (shiftNow)  bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strobes.parTrack = ~modeS & ~csS & ~wrS;
    strobes.shiftEn  = shiftNow;
    strobes.serLoad  = shiftNow & (bitCnt == LAST_BIT);
    strobes.bitIn    = dataS;
    strobes.dacTrack = ~ldS & ~strobes.parTrack & ~strobes.serLoad;
  end

  // R6: a frame delivers exactly one load, never on back-to-back cycles
  p_single_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.serLoad |=> !strobes.serLoad);

  // R10: the counter never passes the frame length
  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == FULL_CNT && frameOpen) |=> (bitCnt == FULL_CNT || !frameOpen || bitCnt == '0));

endmodule

// File: rtl/dacfe_dpath.sv
module dacfe_dpath
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [DATA_W-1:0]        parBus,
  input  dacStrobes_t              strobes,
  output logic [DATA_W-1:0]        dacCode,
  output logic signed [DATA_W-1:0] dacValue
);

  logic [DATA_W-1:0] parSync;
  logic [DATA_W-2:0] shiftReg;
  logic [DATA_W-1:0] inputLatch;
  logic [DATA_W-1:0] dacLatch;

  // Bus goes through the same stage count as the control pins
  dacfe_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) uBusSync (
    .clk (clk),
    .rstN(rstN),
    .din (parBus),
    .dout(parSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[DATA_W-3:0], strobes.bitIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 inputLatch <= '0;
    else if (strobes.serLoad)  inputLatch <= {shiftReg, strobes.bitIn};
    else if (strobes.parTrack) inputLatch <= parSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 dacLatch <= '0;
    else if (strobes.dacTrack) dacLatch <= inputLatch;
  end

  assign dacCode  = dacLatch;
  assign dacValue = $signed(dacLatch);

  // R4: no update of the output register while a parallel write is open
  p_dac_hold_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.parTrack |=> $stable(dacLatch));

  // R3: staging register changes only on a write or a frame load
  p_input_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.parTrack && !strobes.serLoad) |=> $stable(inputLatch));

  // R5: the output register moves only when the transfer is enabled
  p_dac_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacLatch) |-> $past(strobes.dacTrack));

endmodule

// File: rtl/dac_frontend.sv
module dac_frontend
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int FRAME_LEN = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serialSel,
  input  logic [DATA_W-1:0]        parBus,
  input  logic                     chipSelN,
  input  logic                     writeN,
  input  logic                     loadN,
  input  logic                     serClk,
  input  logic                     serFrameN,
  input  logic                     serData,
  output logic [DATA_W-1:0]        dacCode,
  output logic signed [DATA_W-1:0] dacValue
);

  dacStrobes_t strobes;

  dacfe_ctrl #(.FRAME_LEN(FRAME_LEN), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .serialSel(serialSel),
    .chipSelN (chipSelN),
    .writeN   (writeN),
    .loadN    (loadN),
    .serClk   (serClk),
    .serFrameN(serFrameN),
    .serData  (serData),
    .strobes  (strobes)
  );

  dacfe_dpath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .parBus  (parBus),
    .strobes (strobes),
    .dacCode (dacCode),
    .dacValue(dacValue)
  );

endmodule

// File: tb/sim_dac_frontend.sv
module sim_dac_frontend;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialSel = 1'b0;
  logic [13:0] parBus = '0;
  logic chipSelN = 1'b1, writeN = 1'b1, loadN = 1'b1;
  logic serClk = 1'b1, serFrameN = 1'b1, serData = 1'b0;
  logic [13:0] dacCode;
  logic signed [13:0] dacValue;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dac_frontend u0 (
    .clk(clk), .rstN(rstN), .serialSel(serialSel), .parBus(parBus),
    .chipSelN(chipSelN), .writeN(writeN), .loadN(loadN),
    .serClk(serClk), .serFrameN(serFrameN), .serData(serData),
    .dacCode(dacCode), .dacValue(dacValue)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  function automatic int toSigned(input int code);
    return (code >= 8192) ? code - 16384 : code;
  endfunction

  task automatic parWrite(input logic [13:0] code);
    parBus = code; chipSelN = 1'b0; writeN = 1'b0;
    waitCyc(5);
    writeN = 1'b1; chipSelN = 1'b1;
    waitCyc(6);
  endtask

  task automatic pulseLoad();
    loadN = 1'b0; waitCyc(6);
    loadN = 1'b1; waitCyc(4);
  endtask

  task automatic sendFrame(input logic [31:0] bits, input int n);
    serFrameN = 1'b0; waitCyc(3);
    for (int i = 0; i < n; i++) begin
      serData = bits[n-1-i];
      waitCyc(3);
      serClk = 1'b0; waitCyc(3);
      serClk = 1'b1;
    end
    waitCyc(3);
    serFrameN = 1'b1; waitCyc(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(3);

    // R1: reset state
    check("R1 code", int'(dacCode), 0);
    check("R1 value", int'(dacValue), 0);

    // Parallel sweep (R2, R5, R9)
    prev = 0;
    for (int k = 0; k < 68; k++) begin
      int code;
      if (k == 64) code = 14'h1FFF;
      else if (k == 65) code = 14'h2000;
      else if (k == 66) code = 14'h3FFF;
      else if (k == 67) code = 0;
      else code = (k * 263 + 1) % 16384;
      parWrite(code[13:0]);
      check("R5 hold while load high", int'(dacCode), prev);
      pulseLoad();
      check("R2 parallel load", int'(dacCode), code);
      check("R9 signed view", int'(dacValue), toSigned(code));
      prev = code;
    end

    // R3: bus changes after write closes are ignored
    parBus = 14'h1234; chipSelN = 1'b0; writeN = 1'b0; waitCyc(5);
    writeN = 1'b1; waitCyc(2);
    parBus = 14'h0ABC; waitCyc(4);
    chipSelN = 1'b1; waitCyc(2);
    parBus = 14'h3333; waitCyc(4);
    pulseLoad();
    check("R3 capture at write end", int'(dacCode), 14'h1234);

    // R4: interlock with load held low
    loadN = 1'b0; waitCyc(6);
    parBus = 14'h2A5A; chipSelN = 1'b0; writeN = 1'b0; waitCyc(8);
    check("R4 hold during write", int'(dacCode), 14'h1234);
    parBus = 14'h0F0F; waitCyc(6);
    check("R4 hold during bus change", int'(dacCode), 14'h1234);
    chipSelN = 1'b1; writeN = 1'b1; waitCyc(6);
    check("R4 update at write end", int'(dacCode), 14'h0F0F);
    loadN = 1'b1; waitCyc(4);

    // Serial sweep (R6, R9)
    serialSel = 1'b1; waitCyc(4);
    for (int k = 0; k < 36; k++) begin
      int code;
      logic [15:0] frm;
      if (k == 32) code = 14'h1FFF;
      else if (k == 33) code = 14'h2000;
      else if (k == 34) code = 14'h3FFF;
      else if (k == 35) code = 14'h0001;
      else code = (k * 517 + 3) % 16384;
      frm = {2'(k % 4), code[13:0]};
      sendFrame({16'h0, frm}, 16);
      pulseLoad();
      check("R6 serial frame", int'(dacCode), code);
      check("R9 serial signed", int'(dacValue), toSigned(code));
      prev = code;
    end

    // R7: short frame dropped
    sendFrame({22'h0, 10'h3FF}, 10);
    pulseLoad();
    check("R7 partial frame", int'(dacCode), prev);

    // R10: bits beyond the 16th ignored
    sendFrame({16'h0, 16'h0C35, 4'hF}, 20);
    pulseLoad();
    check("R10 extra bits", int'(dacCode), 14'h0C35);

    // R8: parallel pins ignored in serial mode
    parWrite(14'h2222);
    pulseLoad();
    check("R8 parallel in serial mode", int'(dacCode), 14'h0C35);

    // R8: serial pins ignored in parallel mode
    serialSel = 1'b0; waitCyc(4);
    sendFrame({16'h0, 16'h1111}, 16);
    pulseLoad();
    check("R8 serial in parallel mode", int'(dacCode), 14'h0C35);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

endmodule